// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter (Slave Mode)

This block sends stereo audio samples out on one serial data line. It does not make its own clocks. A bit clock and a word clock come in from outside, and the block samples both with its own system clock. A falling edge of the bit clock is one bit slot. A change of the word clock seen at such an edge marks the start of a channel.

At the start of each channel the block loads the correct word and shifts it out most significant bit first. The data line changes only after falling bit-clock edges, so a receiver can capture it on rising edges.

A static format input picks one of two framings:

- **Left-justified:** the first bit goes out on the same falling edge as the word-clock change, and a high word clock means left.
- **I2S:** the first bit goes out one bit period later, and a low word clock means left.

New samples arrive with a one-cycle valid strobe. They are held until the next frame starts, so a new sample never disturbs a frame that is already being sent.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is high and after reset, the data output is 0. It stays 0 until the first word-clock change that is seen at a bit-clock falling edge.
- R2: When the format input is 1 (left-justified), the left channel is the half-frame in which the word clock is high. The MSB of the new word appears on the falling edge at which the word clock changed.
- R3: When the format input is 0 (I2S), the left channel is the half-frame in which the word clock is low. The MSB appears one falling edge after the word-clock change.
- R4: Each channel word is 24 bits and is sent from MSB to LSB, one bit for each falling edge.
- R5: Once the LSB has been sent, the output is 0 until the next channel word starts. This applies when a half-frame has more bit periods than the word has bits.
- R6: In I2S mode with 24-period half-frames, the first bit slot of each channel carries the LSB of the channel before it.
- R7: A left/right pair delivered in the middle of a frame is not used in the frame being sent. The right word of that frame is still the value held when the frame's left channel started. The new pair is sent from the next frame.
- R8: The data output changes only in the system-clock cycle that follows a sampled falling edge of the bit clock. It holds steady while the bit clock is high.
- R9: The sample inputs are taken only in a cycle where the valid strobe is 1. Changes on them without the strobe are not sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bit and word clocks |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External bit clock |
| wclk_i | input | 1 | External word (channel) clock |
| fmt_lj_i | input | 1 | Framing select: 0 = I2S, 1 = left-justified |
| smp_left_i | input | 24 | Left sample |
| smp_right_i | input | 24 | Right sample |
| smp_valid_i | input | 1 | Strobe that captures both samples |
| sdata_o | output | 1 | Serial data output |

## Verification
In I2S mode with half-frames of exactly 24 bit periods, two things fall on the same falling edge: the last bit of one channel and the detection of the next channel. The word for the new channel then has to load on the following edge, while the LSB still goes out on the boundary edge. The bench provokes this by running 24-period half-frames in I2S. It checks that slot 0 of each channel carries the previous channel's LSB and slot 1 carries the new MSB. A second clash comes from a valid strobe in the middle of a frame, which competes with the frame's held right word. The bench checks this by comparing the right channel of that frame against the old sample.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;

    // Per-cycle events produced by the clock front end.
    typedef struct packed {
        logic fall;       // sampled falling bit-clock edge this cycle
        logic load;       // start shifting a new channel word on this edge
        logic load_left;  // the word to load belongs to the left channel
    } tx_evt_t;

    // Word-clock level that marks the left channel for a framing mode.
    function automatic logic left_level(input fmt_e fmt, input logic wclk);
        return (fmt == FMT_LJ) ? wclk : ~wclk;
    endfunction

endpackage

// File: rtl/aud_ser_edge.sv
module aud_ser_edge
    import aud_ser_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bclk_i,
    input  logic    wclk_i,
    input  fmt_e    fmt,
    output tx_evt_t evt
);

    logic bclk_q;
    logic armed;
    logic wclk_prev;
    logic pend;
    logic pend_left;

    logic fall;
    logic bound;

    assign fall  = bclk_q & ~bclk_i;
    assign bound = fall & armed & (wclk_i != wclk_prev);

    always_comb begin
        evt.fall = fall;
        if (fmt == FMT_LJ) begin
            evt.load      = bound;
            evt.load_left = left_level(fmt, wclk_i);
        end else begin
            evt.load      = fall & pend;
            evt.load_left = pend_left;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q    <= 1'b0;
            armed     <= 1'b0;
            wclk_prev <= 1'b0;
            pend      <= 1'b0;
            pend_left <= 1'b0;
        end else begin
            bclk_q <= bclk_i;
            if (fall) begin
                armed     <= 1'b1;
                wclk_prev <= wclk_i;
                pend      <= (fmt == FMT_I2S) & bound;
                if (bound) begin
                    pend_left <= left_level(fmt, wclk_i);
                end
            end
        end
    end

endmodule

// File: rtl/aud_ser_hold.sv
module aud_ser_hold #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] smp_left_i,
    input  logic [WORD_W-1:0] smp_right_i,
    input  logic              smp_valid_i,
    input  logic              load,
    input  logic              load_left,
    output logic [WORD_W-1:0] next_word
);

    logic [WORD_W-1:0] stage_l;
    logic [WORD_W-1:0] stage_r;
    logic [WORD_W-1:0] frame_r;

    assign next_word = load_left ? stage_l : frame_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_l <= '0;
            stage_r <= '0;
            frame_r <= '0;
        end else begin
            if (smp_valid_i) begin
                stage_l <= smp_left_i;
                stage_r <= smp_right_i;
            end
            // Frame boundary: freeze the right word paired with this left word.
            if (load && load_left) begin
                frame_r <= stage_r;
            end
        end
    end

endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              sdata
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  left_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            left_bits <= '0;
            sdata     <= 1'b0;
        end else if (fall) begin
            if (load) begin
                sdata     <= word[WORD_W-1];
                shreg     <= {word[WORD_W-2:0], 1'b0};
                left_bits <= LAST;
            end else if (left_bits != '0) begin
                sdata     <= shreg[WORD_W-1];
                shreg     <= {shreg[WORD_W-2:0], 1'b0};
                left_bits <= left_bits - 1'b1;
            end else begin
                sdata <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_i,
    input  logic              wclk_i,
    input  logic              fmt_lj_i,
    input  logic [WORD_W-1:0] smp_left_i,
    input  logic [WORD_W-1:0] smp_right_i,
    input  logic              smp_valid_i,
    output logic              sdata_o
);

    fmt_e              fmt;
    tx_evt_t           evt;
    logic [WORD_W-1:0] next_word;

    assign fmt = fmt_e'(fmt_lj_i);

    aud_ser_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .bclk_i (bclk_i),
        .wclk_i (wclk_i),
        .fmt    (fmt),
        .evt    (evt)
    );

    aud_ser_hold #(.WORD_W(WORD_W)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .smp_left_i  (smp_left_i),
        .smp_right_i (smp_right_i),
        .smp_valid_i (smp_valid_i),
        .load        (evt.load),
        .load_left   (evt.load_left),
        .next_word   (next_word)
    );

    aud_ser_shift #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .fall  (evt.fall),
        .load  (evt.load),
        .word  (next_word),
        .sdata (sdata_o)
    );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
    input logic clk,
    input logic rst,
    input logic bclk_i,
    input logic wclk_i,
    input logic fmt_lj_i,
    input logic sdata_o
);

    logic       bq;
    logic       wd;
    logic       seen_lr;
    logic       armed_c;
    logic       wprev_c;
    logic       seen_bd;
    logic [7:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            bq      <= 1'b0;
            wd      <= wclk_i;
            seen_lr <= 1'b0;
            armed_c <= 1'b0;
            wprev_c <= 1'b0;
            seen_bd <= 1'b0;
            slot    <= '0;
        end else begin
            bq <= bclk_i;
            wd <= wclk_i;
            if (wclk_i != wd) seen_lr <= 1'b1;
            if (bq && !bclk_i) begin
                armed_c <= 1'b1;
                wprev_c <= wclk_i;
                if (armed_c && (wclk_i != wprev_c)) begin
                    slot    <= '0;
                    seen_bd <= 1'b1;
                end else if (slot != 8'hFF) begin
                    slot <= slot + 8'd1;
                end
            end
        end
    end

    // R1: reset forces the line low
    a_r1_reset_low: assert property (@(posedge clk) rst |=> sdata_o == 1'b0);

    // R1: silent until a word-clock change has occurred
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !seen_lr |-> sdata_o == 1'b0);

    // R5: zero fill once the word is exhausted
    a_r5_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (seen_bd && (slot >= (fmt_lj_i ? 8'd24 : 8'd25))) |-> sdata_o == 1'b0);

    // R8: output moves only right after a sampled falling bit-clock edge
    a_r8_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata_o) |-> ($past(bclk_i) == 1'b0 && $past(bclk_i, 2) == 1'b1));

endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bclk_i   (bclk_i),
    .wclk_i   (wclk_i),
    .fmt_lj_i (fmt_lj_i),
    .sdata_o  (sdata_o)
);

// File: tb/aud_ser_tx_bench.sv
module aud_ser_tx_bench;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bclk = 1'b1;
    logic         wclk = 1'b0;
    logic         fmt_lj = 1'b1;
    logic [W-1:0] sl = '0;
    logic [W-1:0] sr = '0;
    logic         sv = 1'b0;
    logic         sdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [W-1:0] prev_word;

    always #4 clk = ~clk;

    aud_ser_tx u_aud_ser_tx (
        .clk         (clk),
        .rst         (rst),
        .bclk_i      (bclk),
        .wclk_i      (wclk),
        .fmt_lj_i    (fmt_lj),
        .smp_left_i  (sl),
        .smp_right_i (sr),
        .smp_valid_i (sv),
        .sdata_o     (sdata)
    );

    task automatic check(input string tag, input int slot, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s slot %0d: got %b expected %b", tag, slot, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bit slot: fall (optional word-clock change), sample, rise, re-sample.
    task automatic bit_slot(input bit chg, input logic lvl, input string tag,
                            input int slot, input logic exp);
        logic v;
        @(negedge clk);
        bclk = 1'b0;
        if (chg) wclk = lvl;
        wait_clk(4);
        v = sdata;
        check(tag, slot, v, exp);
        bclk = 1'b1;
        wait_clk(4);
        check("R8", slot, sdata, v);
    endtask

    task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        sl = l; sr = r; sv = 1'b1;
        @(negedge clk);
        sv = 1'b0;
    endtask

    task automatic do_reset(input logic lj);
        @(negedge clk);
        rst = 1'b1;
        fmt_lj = lj;
        bclk = 1'b1;
        wclk = lj ? 1'b0 : 1'b1;   // right-channel level, first change enters left
        sv = 1'b0;
        wait_clk(3);
        check("R1", -1, sdata, 1'b0);
        rst = 1'b0;
        prev_word = '0;
        bit_slot(0, 0, "R1", 0, 1'b0);
        bit_slot(0, 0, "R1", 1, 1'b0);
    endtask

    function automatic logic exp_bit(input logic lj, input int half, input int k,
                                     input logic [W-1:0] word, input logic [W-1:0] prev);
        if (lj) return (k < W) ? word[W-1-k] : 1'b0;
        if (k == 0) return (half == W) ? prev[0] : 1'b0;
        return (k <= W) ? word[W-k] : 1'b0;
    endfunction

    // One frame; optional mid-left update with (ul, ur).
    task automatic run_frame(input string tag, input int half,
                             input logic [W-1:0] l, input logic [W-1:0] r,
                             input bit upd, input logic [W-1:0] ul, input logic [W-1:0] ur);
        for (int ch = 0; ch < 2; ch++) begin
            logic [W-1:0] word = (ch == 0) ? l : r;
            logic lvl = (ch == 0) ? (fmt_lj ? 1'b1 : 1'b0) : (fmt_lj ? 1'b0 : 1'b1);
            for (int k = 0; k < half; k++) begin
                if (upd && ch == 0 && k == 10) push(ul, ur);
                bit_slot(k == 0, lvl, tag, k, exp_bit(fmt_lj, half, k, word, prev_word));
            end
            prev_word = word;
        end
    endtask

    task automatic t_reset_idle;   // R1
        do_reset(1'b1);
        push(24'hFFFFFF, 24'hFFFFFF);
        for (int k = 0; k < 4; k++) bit_slot(0, 0, "R1", k, 1'b0);
    endtask

    task automatic t_lj_long;      // R2 R4 R5
        do_reset(1'b1);
        push(24'hA5C3F1, 24'h5A3C0F);
        run_frame("R2", 32, 24'hA5C3F1, 24'h5A3C0F, 0, '0, '0);
        push(24'h800001, 24'h7FFFFE);
        run_frame("R4", 32, 24'h800001, 24'h7FFFFE, 0, '0, '0);
    endtask

    task automatic t_i2s_long;     // R3 R5
        do_reset(1'b0);
        push(24'hC0FFEE, 24'h123457);
        run_frame("R3", 32, 24'hC0FFEE, 24'h123457, 0, '0, '0);
        push(24'hFFFFFF, 24'hFFFFFF);
        run_frame("R5", 32, 24'hFFFFFF, 24'hFFFFFF, 0, '0, '0);
    endtask

    task automatic t_i2s_tight;    // R6
        do_reset(1'b0);
        push(24'h9ABCDF, 24'h3579BD);
        run_frame("R6", 24, 24'h9ABCDF, 24'h3579BD, 0, '0, '0);
        push(24'h000001, 24'hFFFFFE);
        run_frame("R6", 24, 24'h000001, 24'hFFFFFE, 0, '0, '0);
    endtask

    task automatic t_lj_tight;     // R2 R4
        do_reset(1'b1);
        push(24'hF0F0F1, 24'h0F0F0F);
        run_frame("R2", 24, 24'hF0F0F1, 24'h0F0F0F, 0, '0, '0);
    endtask

    task automatic t_midframe;     // R7
        do_reset(1'b1);
        push(24'h111111, 24'h222223);
        run_frame("R7", 32, 24'h111111, 24'h222223, 1, 24'hEEEEEE, 24'hDDDDDD);
        run_frame("R7", 32, 24'hEEEEEE, 24'hDDDDDD, 0, '0, '0);
    endtask

    task automatic t_novalid;      // R9
        do_reset(1'b0);
        push(24'h6B6B6B, 24'h494949);
        @(negedge clk);
        sl = 24'hFFFFFF; sr = 24'h000000;
        run_frame("R9", 32, 24'h6B6B6B, 24'h494949, 0, '0, '0);
    endtask

    initial begin
        t_reset_idle();
        t_lj_long();
        t_i2s_long();
        t_i2s_tight();
        t_lj_tight();
        t_midframe();
        t_novalid();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule